// File: doc/BRIEF.md
# Saturating Serial Pulse Counter

This block watches a single-bit serial stream, sampled on each rising clock edge, and counts the complete pulses in it. A pulse is a run of one or more low samples, then one or more high samples, then a low sample again. The pulse is counted at the high-to-low transition that closes it. After reset the block waits for the stream to go low, so a line that is already high when reset is released does not produce a count.

The tally is held in a register whose width and ceiling are parameters (4 bits and 15 by default). If another pulse completes while the tally sits at its ceiling, the block enters a terminal fault state. The tally then stays at the ceiling and the overflow flag goes high. Only reset leaves that state. A host reads the tally and the flag directly as registered levels.

Top module: `pulse_tally`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `pulse_count` becomes 0 and `overflow` becomes 0 after that edge (synchronous, active high).
- R2: `serial_in` is sampled only on rising edges, and `pulse_count` and `overflow` change only just after a rising edge.
- R3: After reset, high samples that come before the first low sample never add to `pulse_count`.
- R4: A low sample that follows one or more high samples, which themselves followed a low sample, raises `pulse_count` by exactly one after that edge, if the count was below the ceiling `CNT_MAX`.
- R5: Repeated low samples or repeated high samples of any length add nothing. A pulse of any run lengths counts once.
- R6: If a pulse completes while `pulse_count` equals `CNT_MAX`, `overflow` goes to 1 after that edge and `pulse_count` stays at `CNT_MAX`. `pulse_count` never exceeds `CNT_MAX`.
- R7: Once `overflow` is 1, it stays 1 and `pulse_count` stays frozen, whatever `serial_in` does, until reset.
- R8: `overflow` is 0 whenever the block has not overflowed since the last reset.
- R9: Reset from the overflow state returns to the initial state: the flag clears and leading high samples are again ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial bit stream being watched |
| pulse_count | output | CNT_W | Registered number of completed pulses, saturating at CNT_MAX |
| overflow | output | 1 | High while in the terminal overflow state |

## Verification
The assertions assume that `serial_in` is a clean synchronous level, known at every sampling edge, and that `rst` is held high from time zero until the first edges have passed. The bench drives `serial_in` and `rst` only on falling edges and starts with reset asserted, so every sample is stable and defined. The stimulus covers every 10-bit pattern after reset and long streams with random run lengths. Other runs push the tally through its ceiling and into the fault state and then out again by reset.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_GAP   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_FAULT = 2'd3
  } phase_t;
endpackage

// File: rtl/pt_phase_fsm.sv
module pt_phase_fsm
  import pulse_tally_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  input  logic at_limit,
  output logic bump,
  output logic fault
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    bump    = 1'b0;
    unique case (phase_q)
      PH_START: if (!serial_in) phase_d = PH_GAP;
      PH_GAP:   if (serial_in)  phase_d = PH_HIGH;
      PH_HIGH: begin
        if (!serial_in) begin
          if (at_limit) begin
            phase_d = PH_FAULT;
          end else begin
            phase_d = PH_GAP;
            bump    = 1'b1;
          end
        end
      end
      PH_FAULT: phase_d = PH_FAULT;
      default:  phase_d = PH_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_START;
    else     phase_q <= phase_d;
  end

  assign fault = (phase_q == PH_FAULT);
endmodule

// File: rtl/pt_sat_counter.sv
module pt_sat_counter #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] value,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst)                        value_q <= '0;
    else if (bump && value_q != LIMIT) value_q <= value_q + ONE;
  end

  assign value    = value_q;
  assign at_limit = (value_q == LIMIT);
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serial_in,
  output logic [CNT_W-1:0] pulse_count,
  output logic             overflow
);
  logic bump;
  logic at_limit;
  logic fault;

  pt_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .serial_in (serial_in),
    .at_limit  (at_limit),
    .bump      (bump),
    .fault     (fault)
  );

  pt_sat_counter #(
    .CNT_W   (CNT_W),
    .CNT_MAX (CNT_MAX)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bump     (bump),
    .value    (pulse_count),
    .at_limit (at_limit)
  );

  assign overflow = fault;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = (1 << CNT_W) - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             serial_in,
  input logic [CNT_W-1:0] pulse_count,
  input logic             overflow
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pulse_count == '0) && !overflow);

  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pulse_count != $past(pulse_count)) |->
      (pulse_count == $past(pulse_count) + ONE));

  a_r3_count_on_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pulse_count == $past(pulse_count) + ONE) |-> !$past(serial_in));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    pulse_count <= LIMIT);

  a_r6_fault_at_ceiling: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(overflow)) |-> (pulse_count == LIMIT));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow && $stable(pulse_count));
endmodule

bind pulse_tally pt_checker #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .serial_in   (serial_in),
  .pulse_count (pulse_count),
  .overflow    (overflow)
);

// File: tb/sim_pulse_tally.sv
`timescale 1ns/100ps
module sim_pulse_tally;
  localparam int W   = 4;
  localparam int MAX = 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         serial_in = 1'b0;
  logic [W-1:0] pulse_count;
  logic         overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model: 0 waiting for low, 1 low seen, 2 high seen, 3 overflowed
  int m_state = 0;
  int m_cnt   = 0;

  pulse_tally #(.CNT_W(W), .CNT_MAX(MAX)) u0 (
    .clk         (clk),
    .rst         (rst),
    .serial_in   (serial_in),
    .pulse_count (pulse_count),
    .overflow    (overflow)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic b);
    if (rst) begin
      m_state = 0; m_cnt = 0;
    end else begin
      case (m_state)
        0: if (!b) m_state = 1;
        1: if (b)  m_state = 2;
        2: if (!b) begin
             if (m_cnt == MAX) m_state = 3;
             else begin m_cnt = m_cnt + 1; m_state = 1; end
           end
        default: m_state = 3;
      endcase
    end
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic tick(input logic b, input string tag);
    serial_in = b;
    @(posedge clk);
    model(b);
    @(negedge clk);
    chk(int'(pulse_count), m_cnt, {tag, " count"});
    chk(int'(overflow), (m_state == 3) ? 1 : 0, {tag, " flag"});
  endtask

  task automatic do_reset(input logic b);
    rst = 1'b1;
    tick(b, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    // R1: reset state
    chk(int'(pulse_count), 0, "R1 reset count");
    chk(int'(overflow), 0, "R1 reset flag");

    // R3: leading highs ignored
    repeat (5) tick(1'b1, "R3");
    tick(1'b0, "R3");
    chk(int'(pulse_count), 0, "R3 leading high not counted");
    tick(1'b1, "R4");
    chk(int'(pulse_count), 0, "R2 no count while high");
    tick(1'b0, "R4");
    chk(int'(pulse_count), 1, "R4 one pulse counted");

    // R5: long runs count once
    repeat (7) tick(1'b0, "R5");
    repeat (9) tick(1'b1, "R5");
    tick(1'b0, "R5");
    chk(int'(pulse_count), 2, "R5 long runs single pulse");

    // near-exhaustive sweep: every 10-bit pattern after reset
    for (int p = 0; p < 1024; p++) begin
      do_reset(p[0]);
      for (int i = 0; i < 10; i++) tick(p[i], "R4 sweep");
    end

    // R6/R7: reach ceiling, then overflow
    do_reset(1'b0);
    tick(1'b0, "R6");
    for (int k = 0; k < MAX; k++) begin
      tick(1'b1, "R6");
      tick(1'b0, "R6");
    end
    chk(int'(pulse_count), MAX, "R6 at ceiling");
    chk(int'(overflow), 0, "R8 no flag at ceiling");
    tick(1'b1, "R6");
    tick(1'b0, "R6");
    chk(int'(overflow), 1, "R6 flag on extra pulse");
    chk(int'(pulse_count), MAX, "R6 count held");
    for (int k = 0; k < 40; k++) tick(k[1] ^ k[0], "R7");
    chk(int'(overflow), 1, "R7 flag sticky");
    chk(int'(pulse_count), MAX, "R7 count frozen");

    // R9: reset out of fault, leading highs ignored again
    do_reset(1'b1);
    chk(int'(overflow), 0, "R9 flag cleared");
    repeat (3) tick(1'b1, "R9");
    chk(int'(pulse_count), 0, "R9 leading high ignored");
    tick(1'b0, "R9"); tick(1'b1, "R9"); tick(1'b0, "R9");
    chk(int'(pulse_count), 1, "R9 counting resumes");

    // random run-length streams
    for (int s = 0; s < 30; s++) begin
      logic lvl;
      do_reset(1'b1);
      lvl = s[0];
      for (int r = 0; r < 60; r++) begin
        int len;
        len = 1 + int'($urandom_range(4, 0));
        for (int j = 0; j < len; j++) tick(lvl, "R5 random");
        lvl = ~lvl;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule